// File: doc/BRIEF.md
# BCD Countdown Timer

This block counts down a time of hours, minutes and seconds held as two-digit BCD fields. Software reads and writes it through one 32-bit register. The block steps once per second. It finds the second boundary by counting strobes from a shared fraction counter: each strobe marks one carry out of that lower fraction. The block keeps its own private upper subsecond counter, `SUB_W` bits wide, and a wrap of that counter ends a second.

The meaning of a write depends on the state and on the value written:
- An all-zero write pauses the count and keeps the remaining time.
- A write of the run bit alone resumes the count.
- An all-zero write while the timer is stopped at zero restores the time captured at the last start.
- Any other value loads a new time. A field written as `8'hFF` keeps its present value. Bit 24 starts the count in the same write.

When the count reaches zero the timer stops, sets its trigger flag and raises the interrupt for one clock.

Top module: `bcd_countdown_timer`

## Requirements
- R1: After reset the register reads 0 and `irq_o` is low.
- R2: While running, the time drops by one second on the cycle that brings the count of `frac_carry_i` strobes since the last load to 2^SUB_W (256 by default). Strobes are counted only while running and in cycles with no write. The count is cleared by any write that loads or restores a time, and it is kept across a pause and resume.
- R3: The step that reaches 00:00:00 clears the run bit (24) and sets the trigger flag (25). On the next cycle `irq_o` is high for exactly one clock. The interrupt does not pulse again until the timer is restarted.
- R4: Any write clears the trigger flag.
- R5: A write of 0 while running clears the run bit and keeps the remaining time.
- R6: A write of exactly 0x0100_0000 while stopped with a nonzero time sets the run bit and keeps the time and the partial subsecond count. While running, the same write has no effect.
- R7: Every start, whether by load or by resume, captures the time it starts from. A write of 0 while stopped at 00:00:00 restores that captured time and leaves the timer stopped. A write of 0 while stopped at a nonzero time changes nothing.
- R8: Any other write loads seconds from bits 7:0, minutes from bits 15:8 and hours from bits 23:16, and sets the run bit from bit 24. A load whose resulting time is zero stays stopped.
- R9: A field written as 8'hFF keeps its present value during a load.
- R10: Decrement uses BCD borrow. Seconds go from 00 to 59 and borrow a minute. Minutes go from 00 to 59 and borrow an hour.
- R11: Readback is {6'b0, trigger, run, hours, minutes, seconds}. Bit 25 of written data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frac_carry_i | input | 1 | One-cycle carry strobe from the shared lower fraction counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register readback |
| irq_o | output | 1 | One-cycle interrupt on expiry |

## Verification
The assertions check these on every cycle:
- The interrupt is a single cycle and follows a stopped, triggered state.
- A write always clears the trigger flag.
- A pause freezes the time.
- An `8'hFF` seconds field survives a load.
- The time never moves without a carry strobe.

Only the directed scenarios can show the rest:
- The exact count of strobes per second.
- The borrow chain across minutes and hours.
- Reload of the captured start time.
- Whether the subsecond count is kept or cleared across pause, resume and reload.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int FIELD_W = 8;
  localparam int NUM_FIELDS = 3;
  localparam int TIME_W = FIELD_W * NUM_FIELDS;
  localparam int RUN_BIT = 24;
  localparam int TRIG_BIT = 25;
  localparam logic [FIELD_W-1:0] KEEP_CODE = 8'hFF;
  localparam logic [31:0] RESUME_CODE = 32'h0100_0000;
  typedef logic [TIME_W-1:0] hms_t;
endpackage

// File: rtl/cdt_subsec.sv
module cdt_subsec #(
  parameter int SUB_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  output logic wrap_o
);
  logic [SUB_W-1:0] cnt_q;

  assign wrap_o = adv_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cdt_bcd_dec.sv
module cdt_bcd_dec
  import cdt_pkg::*;
(
  input  hms_t t_i,
  output hms_t t_o,
  output logic zero_o
);
  logic [NUM_FIELDS:0] borrow;
  assign borrow[0] = 1'b1;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam logic [FIELD_W-1:0] WRAP = (f < NUM_FIELDS - 1) ? 8'h59 : 8'h99;
    logic [FIELD_W-1:0] v, r;
    assign v = t_i[f*FIELD_W +: FIELD_W];
    always_comb begin
      r = v;
      borrow[f+1] = 1'b0;
      if (borrow[f]) begin
        if (v == '0) begin
          r = WRAP;
          borrow[f+1] = 1'b1;
        end else if (v[3:0] == 4'h0) begin
          r = {v[7:4] - 4'h1, 4'h9};
        end else begin
          r = {v[7:4], v[3:0] - 4'h1};
        end
      end
    end
    assign t_o[f*FIELD_W +: FIELD_W] = r;
  end

  assign zero_o = (t_o == '0);
endmodule

// File: rtl/cdt_field_merge.sv
module cdt_field_merge
  import cdt_pkg::*;
(
  input  hms_t cur_i,
  input  hms_t wr_i,
  output hms_t out_o
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign out_o[f*FIELD_W +: FIELD_W] =
      (wr_i[f*FIELD_W +: FIELD_W] == KEEP_CODE) ? cur_i[f*FIELD_W +: FIELD_W]
                                                : wr_i[f*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer
  import cdt_pkg::*;
#(
  parameter int SUB_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frac_carry_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  hms_t time_q, time_d, last_q, last_d, dec_time, merged;
  logic run_q, run_d, trig_q, trig_d, irq_q;
  logic dec_zero, sub_adv, sub_clr, sec_tick, expire;
  logic wr_zero, wr_resume, time_zero;

  assign wr_zero   = (wr_data_i == 32'h0);
  assign wr_resume = (wr_data_i == RESUME_CODE);
  assign time_zero = (time_q == '0);
  assign sub_adv   = run_q & frac_carry_i & ~wr_en_i;

  cdt_subsec #(.SUB_W(SUB_W)) u_subsec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (sub_adv),
    .clr_i  (sub_clr),
    .wrap_o (sec_tick)
  );

  cdt_bcd_dec u_dec (
    .t_i    (time_q),
    .t_o    (dec_time),
    .zero_o (dec_zero)
  );

  cdt_field_merge u_merge (
    .cur_i (time_q),
    .wr_i  (wr_data_i[TIME_W-1:0]),
    .out_o (merged)
  );

  always_comb begin
    time_d  = time_q;
    run_d   = run_q;
    trig_d  = trig_q;
    last_d  = last_q;
    sub_clr = 1'b0;
    expire  = 1'b0;
    if (wr_en_i) begin
      trig_d = 1'b0;
      if (wr_zero) begin
        if (run_q) begin
          run_d = 1'b0;
        end else if (time_zero) begin
          time_d  = last_q;
          sub_clr = 1'b1;
        end
      end else if (wr_resume) begin
        if (!run_q && !time_zero) begin
          run_d  = 1'b1;
          last_d = time_q;
        end
      end else begin
        time_d  = merged;
        sub_clr = 1'b1;
        run_d   = wr_data_i[RUN_BIT] && (merged != '0);
        if (run_d) last_d = merged;
      end
    end else if (sec_tick) begin
      time_d = dec_time;
      if (dec_zero) begin
        run_d  = 1'b0;
        trig_d = 1'b1;
        expire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      last_q <= '0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      time_q <= time_d;
      last_q <= last_d;
      run_q  <= run_d;
      trig_q <= trig_d;
      irq_q  <= expire;
    end
  end

  assign rd_data_o = {6'b0, trig_q, run_q, time_q};
  assign irq_o     = irq_q;

  p_irq_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_data_o[TRIG_BIT] && !rd_data_o[RUN_BIT] && rd_data_o[TIME_W-1:0] == '0));

  p_trig_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !rd_data_o[TRIG_BIT]);

  p_pause_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_zero && run_q) |=>
      (!rd_data_o[RUN_BIT] && $stable(rd_data_o[TIME_W-1:0])));

  p_keep_sec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_zero && !wr_resume && wr_data_i[7:0] == KEEP_CODE) |=>
      $stable(rd_data_o[7:0]));

  p_no_carry_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !frac_carry_i) |=> $stable(rd_data_o[TIME_W-1:0]));
endmodule

// File: tb/bcd_countdown_timer_tb.sv
`timescale 1ns/1ps
module bcd_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frac = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bcd_countdown_timer #(.SUB_W(8)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frac_carry_i (frac),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd),
    .irq_o        (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic carries(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frac = 1'b1;
    end
    @(negedge clk);
    frac = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 readback", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_borrow;
    wr(32'h0100_0100);
    check("R8 load start", rd, 32'h0100_0100);
    carries(255);
    check("R2 no step at 255", rd, 32'h0100_0100);
    carries(1);
    check("R10 minute borrow", rd, 32'h0100_0059);
    wr(32'h0101_0000);
    carries(256);
    check("R10 hour borrow", rd, 32'h0100_5959);
  endtask

  task automatic t_expiry;
    wr(32'h0100_0001);
    carries(255);
    check("R3 before expiry", rd, 32'h0100_0001);
    check("R3 irq low before", {31'b0, irq}, 32'h0);
    carries(1);
    check("R3 expiry state", rd, 32'h0200_0000);
    check("R3 irq pulse", {31'b0, irq}, 32'h1);
    carries(1);
    check("R3 irq single", {31'b0, irq}, 32'h0);
    carries(300);
    check("R3 no repeat", {31'b0, irq}, 32'h0);
    wr(32'h0);
    check("R7 R4 reload and clear", rd, 32'h0000_0001);
    wr(32'h0100_0000);
    carries(256);
    check("R3 second expiry", rd, 32'h0200_0000);
    wr(32'h0000_0030);
    check("R4 load clears trigger", rd, 32'h0000_0030);
  endtask

  task automatic t_pause_resume;
    wr(32'h0100_1000);
    carries(100);
    wr(32'h0);
    check("R5 pause keeps time", rd, 32'h0000_1000);
    carries(500);
    check("R5 paused no count", rd, 32'h0000_1000);
    wr(32'h0100_0000);
    check("R6 resume", rd, 32'h0100_1000);
    wr(32'h0100_0000);
    check("R6 resume while running", rd, 32'h0100_1000);
    carries(155);
    check("R6 subsec kept 155", rd, 32'h0100_1000);
    carries(1);
    check("R6 subsec kept step", rd, 32'h0100_0959);
    wr(32'h0);
    wr(32'h0);
    check("R7 zero at nonzero stopped", rd, 32'h0000_0959);
  endtask

  task automatic t_fields;
    wr(32'h0012_3456);
    check("R8 load stopped", rd, 32'h0012_3456);
    wr(32'h00FF_07FF);
    check("R9 keep fields", rd, 32'h0012_0756);
    wr(32'h0200_0005);
    check("R11 bit25 ignored", rd, 32'h0000_0005);
    wr(32'h0000_0000);
    wr(32'h0000_0000);
    wr(32'hFC00_0000 | 32'h0000_0000);
    check("R11 high bits read zero", rd, 32'h0000_0000);
    wr(32'h01FF_FFFF);
    check("R8 start at zero stays stopped", rd, 32'h0000_0000);
  endtask

  task automatic t_subsec_clear;
    wr(32'h0100_0005);
    carries(200);
    wr(32'h0100_0005);
    carries(255);
    check("R2 load clears subsec", rd, 32'h0100_0005);
    carries(1);
    check("R2 step after reload", rd, 32'h0100_0004);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_borrow();
    t_expiry();
    t_pause_resume();
    t_fields();
    t_subsec_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule